// File: doc/BRIEF.md
# Cache Flush Sequencer

This block orders the work a processor core does when a system asks it to empty its caches through an active-low request pin. It first commands the writeback engine to push every modified data-cache line out to memory. Once that finishes, it commands invalidation of the instruction and data caches. Where the role calls for it, it then commands the bus unit to run a flush-acknowledge special cycle. Each of these engines lives outside the block and is driven by a one-clock start strobe. The engine answers with a one-clock done or ready strobe.

The core may run alone or as half of a two-processor pair. In a pair, the secondary core flushes first and stays silent on the bus. The primary core waits for a peer-finished strobe, then flushes and runs the acknowledge cycle. In a pair, the request must already be released one clock before the ready strobe that ends the acknowledge cycle. The block reports a breach of this rule on a protocol-error output.

The same request pin doubles as a strap. If it is low on the last clock of reset, the core goes into a three-state test mode instead of normal operation. It stays there until the next reset. All inputs are assumed synchronous to `clk`.

Top module: `flush_seq`

## Requirements
- R1: During reset and on the first clock after it, every strobe output, `busy`, `proto_err` and `test_mode` are low when the request pin was high during reset.
- R2: When idle and armed, a low `flush_n` in a single-core or secondary role gives a one-clock `wb_start` pulse on the clock after the one that sampled it.
- R3: `inv_start` pulses exactly once per flush, on the clock after `wb_done` is sampled, and never before `wb_start`.
- R4: In single-core mode (`pair_mode`=0, `is_primary` ignored), `inv_done` leads to one `ack_start` pulse, and `ack_ready` then leads to one `flush_done` pulse.
- R5: In the secondary role (`pair_mode`=1, `is_primary`=0), `inv_done` leads straight to `flush_done` with no `ack_start`.
- R6: In the primary role (`pair_mode`=1, `is_primary`=1), no `wb_start` occurs until `peer_done` has been sampled high. The flush then runs writeback, invalidation and the acknowledge cycle.
- R7: If `flush_n` is low on the last clock of reset, `test_mode` rises on the first clock after reset and stays high until reset is asserted again.
- R8: While `test_mode` is high, a low `flush_n` starts nothing: `wb_start` and `busy` stay low.
- R9: After a flush completes, a request held low starts no new flush. A new flush needs `flush_n` to be seen high while idle.
- R10: In paired mode, `ack_ready` sampled while `flush_n` is low, or was low on the preceding clock, gives a one-clock `proto_err` pulse on the next clock. Single-core flushes never raise it.
- R11: `busy` is high from the clock after acceptance through the clock that shows `flush_done`, and low on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_n | input | 1 | Active-low flush request; also the test-mode strap at reset release |
| pair_mode | input | 1 | 1 when running as one of a processor pair |
| is_primary | input | 1 | 1 for the primary role in a pair |
| peer_done | input | 1 | Strobe: the peer has finished its flush |
| wb_start | output | 1 | Strobe to the modified-line writeback engine |
| wb_done | input | 1 | Strobe: writeback of modified lines finished |
| inv_start | output | 1 | Strobe to invalidate both caches |
| inv_done | input | 1 | Strobe: invalidation finished |
| ack_start | output | 1 | Strobe to the bus unit to run the acknowledge cycle |
| ack_ready | input | 1 | Ready strobe ending the acknowledge cycle |
| flush_done | output | 1 | One-clock pulse when the flush sequence ends |
| busy | output | 1 | High while a flush is in progress |
| test_mode | output | 1 | Three-state test mode enable |
| proto_err | output | 1 | Pulse on a late-release breach of the pair rule |

## Verification
The embedded properties check, on every clock, the following:
- the start strobes never overlap;
- invalidation follows a writeback completion;
- a secondary never starts an acknowledge cycle;
- a primary writeback is preceded by the peer strobe;
- test mode latches and holds while the sequencer stays idle;
- every error pulse traces back to a paired ready strobe.

The end-to-end order of a whole flush can only be shown by the bench's role-by-role scenarios. The same holds for the exact latency from request to first strobe, for re-arming after a held request, and for the difference between early and late release in each role.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_WB        = 3'd1,
    S_INV       = 3'd2,
    S_WAIT_PEER = 3'd3,
    S_ACK       = 3'd4,
    S_DONE      = 3'd5
  } fs_state_e;

  typedef struct packed {
    logic paired;
    logic primary;
  } fs_role_t;
endpackage

// File: rtl/fs_strap.sv
module fs_strap (
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  output logic test_mode
);
  logic in_rst_q;
  logic strap_low_q;

  // The strap value is the request level on the final reset clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_rst_q    <= 1'b1;
      strap_low_q <= ~flush_n;
      test_mode   <= 1'b0;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q && strap_low_q) test_mode <= 1'b1;
    end
  end

  // R7: once entered, test mode persists until reset
  p_test_hold_r7: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> test_mode);
endmodule

// File: rtl/fs_arm.sv
module fs_arm (
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  input  logic in_idle,
  input  logic accept,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)                     armed <= 1'b0;
    else if (accept)             armed <= 1'b0;
    else if (in_idle && flush_n) armed <= 1'b1;
  end

  // R9: arming only follows a released request
  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(flush_n));
endmodule

// File: rtl/fs_guard.sv
module fs_guard #(
  parameter int ACK_SETUP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  input  logic in_ack,
  input  logic paired,
  input  logic ack_ready,
  output logic proto_err
);
  localparam int CW = $clog2(ACK_SETUP + 2);

  logic late;

  generate
    if (ACK_SETUP == 0) begin : g_nosetup
      assign late = ~flush_n;
    end else begin : g_setup
      logic [CW-1:0] hi_cnt;
      always_ff @(posedge clk) begin
        if (rst || !flush_n)            hi_cnt <= '0;
        else if (hi_cnt < CW'(ACK_SETUP)) hi_cnt <= hi_cnt + 1'b1;
      end
      assign late = ~flush_n || (hi_cnt < CW'(ACK_SETUP));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= in_ack && paired && ack_ready && late;
  end

  // R10: an error always stems from a paired ready strobe
  p_err_cause_r10: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(ack_ready && paired));
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  input  logic armed,
  input  logic test_mode,
  input  logic pair_mode,
  input  logic is_primary,
  input  logic peer_done,
  input  logic wb_done,
  input  logic inv_done,
  input  logic ack_ready,
  output logic accept,
  output logic in_idle,
  output logic in_ack,
  output logic paired,
  output logic wb_start,
  output logic inv_start,
  output logic ack_start,
  output logic flush_done,
  output logic busy
);
  fs_state_e state, state_n;
  fs_role_t  role_q;

  always_comb begin
    state_n = state;
    accept  = 1'b0;
    case (state)
      S_IDLE: begin
        if (armed && !flush_n && !test_mode) begin
          accept  = 1'b1;
          state_n = (pair_mode && is_primary) ? S_WAIT_PEER : S_WB;
        end
      end
      S_WAIT_PEER: if (peer_done) state_n = S_WB;
      S_WB:        if (wb_done)   state_n = S_INV;
      S_INV: begin
        if (inv_done)
          state_n = (role_q.paired && !role_q.primary) ? S_DONE : S_ACK;
      end
      S_ACK:       if (ack_ready) state_n = S_DONE;
      S_DONE:      state_n = S_IDLE;
      default:     state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      role_q     <= '0;
      wb_start   <= 1'b0;
      inv_start  <= 1'b0;
      ack_start  <= 1'b0;
      flush_done <= 1'b0;
      busy       <= 1'b0;
    end else begin
      state      <= state_n;
      if (accept) role_q <= '{paired: pair_mode, primary: is_primary};
      wb_start   <= (state_n == S_WB)  && (state != S_WB);
      inv_start  <= (state_n == S_INV) && (state != S_INV);
      ack_start  <= (state_n == S_ACK) && (state != S_ACK);
      flush_done <= (state_n == S_DONE);
      busy       <= (state_n != S_IDLE);
    end
  end

  assign in_idle = (state == S_IDLE);
  assign in_ack  = (state == S_ACK);
  assign paired  = role_q.paired;

  // R3: engine strobes never overlap
  p_starts_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_start, inv_start, ack_start}));
  // R3: invalidation follows writeback completion
  p_inv_after_wb_r3: assert property (@(posedge clk) disable iff (rst)
    inv_start |-> $past(wb_done));
  // R5: secondary never runs the acknowledge cycle
  p_no_ack_secondary_r5: assert property (@(posedge clk) disable iff (rst)
    ack_start |-> !(role_q.paired && !role_q.primary));
  // R6: primary writeback waits for the peer
  p_peer_first_r6: assert property (@(posedge clk) disable iff (rst)
    (wb_start && role_q.paired && role_q.primary) |-> $past(peer_done));
  // R8: test mode keeps the sequencer idle
  p_test_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> !busy);
  // R11: completion is reported while still busy
  p_done_busy_r11: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> busy);
endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
  parameter int ACK_SETUP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_n,
  input  logic pair_mode,
  input  logic is_primary,
  input  logic peer_done,
  output logic wb_start,
  input  logic wb_done,
  output logic inv_start,
  input  logic inv_done,
  output logic ack_start,
  input  logic ack_ready,
  output logic flush_done,
  output logic busy,
  output logic test_mode,
  output logic proto_err
);
  logic armed, accept, in_idle, in_ack, paired;

  fs_strap u_strap (
    .clk(clk), .rst(rst), .flush_n(flush_n), .test_mode(test_mode)
  );

  fs_arm u_arm (
    .clk(clk), .rst(rst), .flush_n(flush_n),
    .in_idle(in_idle), .accept(accept), .armed(armed)
  );

  fs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .flush_n(flush_n), .armed(armed),
    .test_mode(test_mode), .pair_mode(pair_mode), .is_primary(is_primary),
    .peer_done(peer_done), .wb_done(wb_done), .inv_done(inv_done),
    .ack_ready(ack_ready), .accept(accept), .in_idle(in_idle),
    .in_ack(in_ack), .paired(paired), .wb_start(wb_start),
    .inv_start(inv_start), .ack_start(ack_start),
    .flush_done(flush_done), .busy(busy)
  );

  fs_guard #(.ACK_SETUP(ACK_SETUP)) u_guard (
    .clk(clk), .rst(rst), .flush_n(flush_n), .in_ack(in_ack),
    .paired(paired), .ack_ready(ack_ready), .proto_err(proto_err)
  );
endmodule

// File: tb/tb_flush_seq.sv
`timescale 1ns/1ps
module tb_flush_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_n = 1'b1, pair_mode = 1'b0, is_primary = 1'b0;
  logic peer_done = 1'b0, wb_done = 1'b0, inv_done = 1'b0, ack_ready = 1'b0;
  logic wb_start, inv_start, ack_start, flush_done, busy, test_mode, proto_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  flush_seq dut (
    .clk(clk), .rst(rst), .flush_n(flush_n), .pair_mode(pair_mode),
    .is_primary(is_primary), .peer_done(peer_done), .wb_start(wb_start),
    .wb_done(wb_done), .inv_start(inv_start), .inv_done(inv_done),
    .ack_start(ack_start), .ack_ready(ack_ready), .flush_done(flush_done),
    .busy(busy), .test_mode(test_mode), .proto_err(proto_err)
  );

  // {pair_mode, is_primary, early_release, expect_ack, expect_err}
  localparam logic [4:0] VECS [7] = '{
    5'b00110,  // single, early release
    5'b00010,  // single, late release: never flagged
    5'b10100,  // secondary, early
    5'b10000,  // secondary, late: no ack cycle so no error
    5'b11110,  // primary, early
    5'b11011,  // primary, late: protocol error
    5'b01010   // single with primary strap set: role ignored
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic run_vec(input logic [4:0] v);
    bit early, eack, eerr, order_ok, peer_given;
    int wb, inv, ack, dn, err, ack_wait, pc, wb_cyc, again;
    early = v[2]; eack = v[1]; eerr = v[0];
    wb = 0; inv = 0; ack = 0; dn = 0; err = 0; ack_wait = 0; pc = 0;
    wb_cyc = -1; again = 0; order_ok = 1; peer_given = 0;
    @(negedge clk);
    pair_mode = v[4]; is_primary = v[3]; flush_n = 1'b1;
    @(negedge clk);
    flush_n = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      wb_done = 0; inv_done = 0; peer_done = 0; ack_ready = 0;
      if (wb_start) begin
        wb++; if (wb_cyc < 0) wb_cyc = c;
        if (inv > 0) order_ok = 0;
        if (v[4] && v[3] && !peer_given) order_ok = 0;
        wb_done = 1;
      end
      if (inv_start) begin
        inv++; if (wb == 0) order_ok = 0;
        inv_done = 1;
        if (early) flush_n = 1'b1;
      end
      if (ack_start) begin
        ack++; if (inv == 0) order_ok = 0;
        ack_wait = 1;
      end else if (ack_wait == 1) begin
        ack_ready = 1; ack_wait = 0;
      end
      if (v[4] && v[3] && !peer_given && busy) begin
        pc++;
        if (pc == 3) begin peer_done = 1; peer_given = 1; end
      end
      if (proto_err) err++;
      if (flush_done) begin
        dn++;
        chk(busy == 1'b1, "R11 busy at done", busy, 1);
        break;
      end
    end
    @(negedge clk);
    wb_done = 0; inv_done = 0; peer_done = 0; ack_ready = 0;
    if (proto_err) err++;
    chk(busy == 1'b0, "R11 busy after done", busy, 0);
    if (!(v[4] && v[3]))
      chk(wb_cyc == 0, "R2 writeback latency", wb_cyc, 0);
    chk(wb == 1, "R2 writeback count", wb, 1);
    chk(inv == 1, "R3 invalidate count", inv, 1);
    chk(order_ok, "R3 R6 strobe order", order_ok, 1);
    chk(ack == int'(eack), eack ? "R4 R6 ack cycle" : "R5 no ack cycle", ack, eack);
    chk(dn == 1, "R4 R5 done pulse", dn, 1);
    chk(err == int'(eerr), "R10 protocol error", err, eerr);
    if (!early) begin
      // request still low: no restart until released (R9)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (wb_start || busy) again++;
      end
      chk(again == 0, "R9 no restart while held", again, 0);
      flush_n = 1'b1;
    end
  endtask

  initial begin
    // R1 reset state with request high
    rst = 1'b1; flush_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({wb_start, inv_start, ack_start, flush_done, busy, proto_err, test_mode} == 7'b0,
        "R1 outputs in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(test_mode == 1'b0, "R1 no test mode", test_mode, 0);
    chk(busy == 1'b0 && wb_start == 1'b0, "R1 idle after reset", busy, 0);

    for (int i = 0; i < 7; i++) run_vec(VECS[i]);

    // R7 strap low at reset release
    @(negedge clk);
    rst = 1'b1; flush_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(test_mode == 1'b1, "R7 test mode entered", test_mode, 1);
    // R8 requests ignored in test mode
    flush_n = 1'b1; pair_mode = 1'b0;
    repeat (2) @(negedge clk);
    flush_n = 1'b0;
    begin
      int hits = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (wb_start || busy) hits++;
      end
      chk(hits == 0, "R8 flush ignored in test mode", hits, 0);
    end
    chk(test_mode == 1'b1, "R7 test mode held", test_mode, 1);
    // reset with strap high leaves test mode
    flush_n = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(test_mode == 1'b0, "R7 test mode cleared by reset", test_mode, 0);
    // normal flush works again
    run_vec(5'b00110);

    summary();
    $finish;
  end
endmodule